// File: doc/BRIEF.md
# Layer-wise Tracklet Road Finder

This block takes the hits of one event from a straw-tube tracking detector, one hit word per cycle, and records each one in an occupancy map. The map has one bit for each layer and each tube position. A second memory, indexed the same way, holds the hit's arrival number within the event. The tube positions of all segments are joined end to end into one closed ring, so a tube at the edge of a segment sits next to the first or last tube of the neighbouring segment.

When the event is closed, the block takes seed hits from the innermost layer and grows a chain from each one outward, one layer per cycle. At each step it takes one free hit among the neighbour candidates in the next layer. Axial layers offer four candidates and stereo layers offer six. Every hit it takes is removed from the map, so no hit serves two chains. A chain that reaches the minimum length is sent out as a burst of hit indices, innermost first, tagged with a tracklet number. When no seed is left, the map is wiped and the block accepts the next event.

Top module: `tracklet_road_finder`

## Requirements
- R1: The hit word packs the segment in bits 28:26, the layer in bits 25:22, the tube in bits 21:16 and the arrival time in bits 15:0. The ring position is segment times TUBES_PER_SEG plus tube. A hit whose segment, layer or tube is at or above its configured count is accepted but never enters the map.
- R2: `hit_ready` is high only while the block is collecting hits, and it falls in the cycle after `evt_end` is sampled. Each accepted hit takes as its index the number of hits accepted earlier in the same event, counting from 0.
- R3: Seeds are taken from layer 0 in ascending ring position, whatever order the hits arrived in.
- R4: Growth into an axial layer tries the offsets 0, +1, -1 and +2 from the current position, in that priority order, and takes the first occupied one.
- R5: Growth into a stereo layer (a layer with its STEREO_MASK bit set) tries the offsets -2 and +3 after the four axial offsets. An offset of +3 is never taken into an axial layer.
- R6: Offsets wrap around the ring, so position RING-1 and position 0 are neighbours, including across segment edges.
- R7: A hit that has been taken as a seed or chain member is never taken again within the event, even when its chain is discarded.
- R8: A chain ends at the outermost layer or at the first layer with no candidate. It is emitted only if it holds at least MIN_HITS hits, one index per cycle, innermost first. `trk_last` marks the final beat, and `trk_num` counts the emitted chains of the event from 0.
- R9: Once seeds are exhausted, the map is cleared. Hits left over from one event never appear in, or extend, a chain of a later event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hit_valid | input | 1 | Hit word present |
| hit_ready | output | 1 | Block is collecting hits |
| hit_word | input | 29 | Packed hit: segment, layer, tube, arrival time |
| evt_end | input | 1 | Close the event and start tracklet building |
| trk_valid | output | 1 | Output beat valid |
| trk_hit_idx | output | IDX_W | Index of a hit in the current tracklet |
| trk_num | output | IDX_W | Tracklet number within the event |
| trk_last | output | 1 | Final hit of the tracklet |

## Verification
The bench keeps the default build: 4 segments of 16 tubes (a 64-position ring), 8 layers with layers 3 to 5 stereo, a minimum of 4 hits and 128 hit slots. With so small a ring, random chains often cross the wrap point between position 63 and position 0, and seeds often compete for the same neighbour hits. The build also leaves room in every field for out-of-range segments, layers and tubes. Directed events pin down offset priority, stereo-only offsets, seed order and the absence of leftovers between events.

// File: rtl/trk_pkg.sv
// Shared field widths, the hit word layout and the sequencer phases for the
// tracklet road finder. Assumes the fixed 29-bit hit word layout.
package trk_pkg;
    localparam int SEG_W  = 3;
    localparam int LAY_W  = 4;
    localparam int TUBE_W = 6;
    localparam int TIME_W = 16;
    localparam int HIT_W  = SEG_W + LAY_W + TUBE_W + TIME_W;

    typedef struct packed {
        logic [SEG_W-1:0]  seg;
        logic [LAY_W-1:0]  layer;
        logic [TUBE_W-1:0] tube;
        logic [TIME_W-1:0] t_arr;
    } hit_t;

    typedef enum logic [2:0] {
        PH_LOAD,
        PH_SEED,
        PH_GROW,
        PH_EMIT,
        PH_CLEAR
    } phase_t;

    // Candidate offset by priority slot: slots 0..3 axial, 4..5 stereo only.
    function automatic int nb_offset(input int k);
        case (k)
            0:       return 0;
            1:       return 1;
            2:       return -1;
            3:       return 2;
            4:       return -2;
            default: return 3;
        endcase
    endfunction
endpackage

// File: rtl/hit_decoder.sv
// Splits a hit word into layer and ring position and flags words whose
// fields fall outside the configured detector. Purely combinational.
module hit_decoder
    import trk_pkg::*;
#(
    parameter int NUM_SEG       = 4,
    parameter int TUBES_PER_SEG = 16,
    parameter int NUM_LAYERS    = 8,
    localparam int RING = NUM_SEG * TUBES_PER_SEG,
    localparam int PW   = $clog2(RING),
    localparam int LW   = $clog2(NUM_LAYERS)
) (
    input  logic [HIT_W-1:0] word_i,
    output logic             in_range_o,
    output logic [LW-1:0]    layer_o,
    output logic [PW-1:0]    pos_o
);
    hit_t h;
    int   gpos;
    logic time_unused;

    // Field extraction, range test and ring position.
    always_comb begin
        h          = hit_t'(word_i);
        in_range_o = (int'(h.seg) < NUM_SEG) && (int'(h.layer) < NUM_LAYERS)
                     && (int'(h.tube) < TUBES_PER_SEG);
        gpos       = int'(h.seg) * TUBES_PER_SEG + int'(h.tube);
        pos_o      = in_range_o ? PW'(gpos) : '0;
        layer_o    = LW'(h.layer);
    end

    // Arrival time plays no part in road finding.
    assign time_unused = ^h.t_arr;
endmodule

// File: rtl/occupancy_map.sv
// One occupancy bit and one hit-index slot per (layer, ring position).
// Writes set a bit, takes clear one bit, a wipe clears them all. Assumes a
// write and a take never target the same cycle (they belong to separate phases).
module occupancy_map #(
    parameter int NUM_LAYERS = 8,
    parameter int RING       = 64,
    parameter int IDX_W      = 7,
    localparam int PW = $clog2(RING),
    localparam int LW = $clog2(NUM_LAYERS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [LW-1:0]    wr_layer,
    input  logic [PW-1:0]    wr_pos,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             take_en,
    input  logic [LW-1:0]    take_layer,
    input  logic [PW-1:0]    take_pos,
    output logic [IDX_W-1:0] take_idx,
    input  logic             wipe,
    input  logic [LW-1:0]    rd_layer,
    output logic [RING-1:0]  rd_row
);
    logic [RING-1:0]  occ     [NUM_LAYERS];
    logic [IDX_W-1:0] idx_mem [NUM_LAYERS][RING];
    logic             occ_any;

    // Occupancy bits: set on hit write, cleared on take or wipe.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) begin
            for (int l = 0; l < NUM_LAYERS; l++) occ[l] <= '0;
        end else begin
            if (wr_en)   occ[wr_layer][wr_pos]     <= 1'b1;
            if (take_en) occ[take_layer][take_pos] <= 1'b0;
        end
    end

    // Hit index memory, written alongside the occupancy bit.
    always_ff @(posedge clk) begin
        if (wr_en) idx_mem[wr_layer][wr_pos] <= wr_idx;
    end

    assign rd_row   = occ[rd_layer];
    assign take_idx = idx_mem[take_layer][take_pos];

    // Any bit left set anywhere in the map.
    always_comb begin
        occ_any = 1'b0;
        for (int l = 0; l < NUM_LAYERS; l++) occ_any = occ_any | (|occ[l]);
    end

    a_r7_take_only_free: assert property (@(posedge clk) disable iff (!rst_n)
        take_en |-> occ[take_layer][take_pos]);
    a_r9_wipe_empties: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> !occ_any);
endmodule

// File: rtl/neighbour_finder.sv
// Picks the first occupied candidate around a ring position in a row of the
// next layer, four offsets for axial rows and six for stereo rows, with wrap.
module neighbour_finder
    import trk_pkg::*;
#(
    parameter int RING = 64,
    localparam int PW = $clog2(RING)
) (
    input  logic [RING-1:0] row_i,
    input  logic [PW-1:0]   pos_i,
    input  logic            stereo_i,
    output logic            found_o,
    output logic [PW-1:0]   pos_o
);
    logic [PW-1:0] cand [6];

    // Candidate ring positions with wrap at both ends.
    generate
        for (genvar k = 0; k < 6; k++) begin : g_cand
            int s;
            always_comb begin
                s = int'(pos_i) + nb_offset(k);
                if (s < 0)          s = s + RING;
                else if (s >= RING) s = s - RING;
                cand[k] = PW'(s);
            end
        end
    endgenerate

    // Priority pick: the lowest slot that is allowed and occupied wins.
    always_comb begin
        found_o = 1'b0;
        pos_o   = '0;
        for (int k = 5; k >= 0; k--) begin
            if ((k < 4 || stereo_i) && row_i[cand[k]]) begin
                found_o = 1'b1;
                pos_o   = cand[k];
            end
        end
    end

    always_comb begin
        a_r4_pick_is_occupied: assert (!found_o || row_i[pos_o]);
    end
endmodule

// File: rtl/tracklet_road_finder.sv
// Collects one event of hits into the occupancy map, then seeds tracklets
// from layer 0 in ascending ring order, grows each outward one layer per
// cycle, emits chains of at least MIN_HITS hits and wipes the map.
// Assumes NUM_LAYERS >= MIN_HITS and a ring of at least 4 positions.
module tracklet_road_finder
    import trk_pkg::*;
#(
    parameter int NUM_SEG       = 4,
    parameter int TUBES_PER_SEG = 16,
    parameter int NUM_LAYERS    = 8,
    parameter logic [NUM_LAYERS-1:0] STEREO_MASK = 8'b0011_1000,
    parameter int MIN_HITS      = 4,
    parameter int MAX_HITS      = 128,
    localparam int RING  = NUM_SEG * TUBES_PER_SEG,
    localparam int PW    = $clog2(RING),
    localparam int LW    = $clog2(NUM_LAYERS),
    localparam int IDX_W = $clog2(MAX_HITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_valid,
    output logic             hit_ready,
    input  logic [HIT_W-1:0] hit_word,
    input  logic             evt_end,
    output logic             trk_valid,
    output logic [IDX_W-1:0] trk_hit_idx,
    output logic [IDX_W-1:0] trk_num,
    output logic             trk_last
);
    phase_t           phase;
    logic [IDX_W:0]   hit_cnt;
    logic [IDX_W-1:0] trk_cnt;
    logic [LW-1:0]    cur_layer;
    logic [PW-1:0]    cur_pos;
    logic [LW-1:0]    emit_ptr;
    logic [IDX_W-1:0] trk_buf [NUM_LAYERS];

    logic             dec_ok;
    logic [LW-1:0]    dec_layer;
    logic [PW-1:0]    dec_pos;
    logic             accept, wr_en;
    logic             at_top;
    logic [LW-1:0]    nxt_layer, rd_layer;
    logic [RING-1:0]  row;
    logic             seed_any;
    logic [PW-1:0]    seed_pos;
    logic             nb_found;
    logic [PW-1:0]    nb_pos;
    logic             take_en;
    logic [LW-1:0]    take_layer;
    logic [PW-1:0]    take_pos;
    logic [IDX_W-1:0] take_idx;
    logic             long_enough;

    hit_decoder #(
        .NUM_SEG(NUM_SEG), .TUBES_PER_SEG(TUBES_PER_SEG), .NUM_LAYERS(NUM_LAYERS)
    ) u_dec (
        .word_i(hit_word), .in_range_o(dec_ok), .layer_o(dec_layer), .pos_o(dec_pos)
    );

    // Hit acceptance and map write enable.
    always_comb begin
        accept = (phase == PH_LOAD) && hit_valid;
        wr_en  = accept && dec_ok && (int'(hit_cnt) < MAX_HITS);
    end

    // Layer selection for the map read and the growth step.
    always_comb begin
        at_top    = (int'(cur_layer) == NUM_LAYERS - 1);
        nxt_layer = at_top ? '0 : cur_layer + 1'b1;
        rd_layer  = (phase == PH_SEED) ? '0 : nxt_layer;
    end

    occupancy_map #(
        .NUM_LAYERS(NUM_LAYERS), .RING(RING), .IDX_W(IDX_W)
    ) u_map (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_layer(dec_layer), .wr_pos(dec_pos), .wr_idx(hit_cnt[IDX_W-1:0]),
        .take_en(take_en), .take_layer(take_layer), .take_pos(take_pos), .take_idx(take_idx),
        .wipe(phase == PH_CLEAR), .rd_layer(rd_layer), .rd_row(row)
    );

    // Lowest occupied position of the innermost layer.
    always_comb begin
        seed_any = 1'b0;
        seed_pos = '0;
        for (int i = RING - 1; i >= 0; i--) begin
            if (row[i]) begin
                seed_any = 1'b1;
                seed_pos = PW'(i);
            end
        end
    end

    neighbour_finder #(.RING(RING)) u_nb (
        .row_i(row), .pos_i(cur_pos), .stereo_i(STEREO_MASK[nxt_layer]),
        .found_o(nb_found), .pos_o(nb_pos)
    );

    // Which hit, if any, is taken out of the map this cycle.
    always_comb begin
        take_en     = ((phase == PH_SEED) && seed_any)
                      || ((phase == PH_GROW) && !at_top && nb_found);
        take_layer  = (phase == PH_SEED) ? '0 : nxt_layer;
        take_pos    = (phase == PH_SEED) ? seed_pos : nb_pos;
        long_enough = (int'(cur_layer) >= MIN_HITS - 1);
    end

    // Phase sequencer with event, chain and emission bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_LOAD;
            hit_cnt   <= '0;
            trk_cnt   <= '0;
            cur_layer <= '0;
            cur_pos   <= '0;
            emit_ptr  <= '0;
        end else begin
            case (phase)
                PH_LOAD: begin
                    if (accept && int'(hit_cnt) < MAX_HITS) hit_cnt <= hit_cnt + 1'b1;
                    if (evt_end) phase <= PH_SEED;
                end
                PH_SEED: begin
                    if (seed_any) begin
                        cur_layer <= '0;
                        cur_pos   <= seed_pos;
                        phase     <= PH_GROW;
                    end else begin
                        phase <= PH_CLEAR;
                    end
                end
                PH_GROW: begin
                    if (take_en) begin
                        cur_layer <= nxt_layer;
                        cur_pos   <= nb_pos;
                    end else if (long_enough) begin
                        emit_ptr <= '0;
                        phase    <= PH_EMIT;
                    end else begin
                        phase <= PH_SEED;
                    end
                end
                PH_EMIT: begin
                    emit_ptr <= emit_ptr + 1'b1;
                    if (emit_ptr == cur_layer) begin
                        trk_cnt <= trk_cnt + 1'b1;
                        phase   <= PH_SEED;
                    end
                end
                default: begin
                    hit_cnt <= '0;
                    trk_cnt <= '0;
                    phase   <= PH_LOAD;
                end
            endcase
        end
    end

    // Chain buffer: the taken hit's index is stored at its layer slot.
    always_ff @(posedge clk) begin
        if (take_en) trk_buf[take_layer] <= take_idx;
    end

    assign hit_ready   = (phase == PH_LOAD);
    assign trk_valid   = (phase == PH_EMIT);
    assign trk_hit_idx = trk_buf[emit_ptr];
    assign trk_num     = trk_cnt;
    assign trk_last    = (phase == PH_EMIT) && (emit_ptr == cur_layer);

    a_r2_end_closes_intake: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_ready && evt_end) |=> !hit_ready);
    a_r8_gap_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_valid && trk_last) |=> !trk_valid);
    a_r8_number_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_valid && !trk_last) |=> (trk_valid && $stable(trk_num)));
    a_r8_min_length: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_valid && trk_last) |-> (int'(emit_ptr) >= MIN_HITS - 1));
endmodule

// File: tb/test_tracklet_road_finder.sv
`timescale 1ns/1ps
module test_tracklet_road_finder;
    localparam int NS = 4, TPS = 16, NL = 8, RING = 64, MINH = 4, MAXH = 128;
    localparam logic [7:0] SMASK = 8'b0011_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hit_valid = 1'b0;
    logic        hit_ready;
    logic [28:0] hit_word = '0;
    logic        evt_end = 1'b0;
    logic        trk_valid;
    logic [6:0]  trk_hit_idx;
    logic [6:0]  trk_num;
    logic        trk_last;

    always #2.5 clk = ~clk;

    tracklet_road_finder i_tracklet_road_finder (
        .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_ready(hit_ready),
        .hit_word(hit_word), .evt_end(evt_end), .trk_valid(trk_valid),
        .trk_hit_idx(trk_hit_idx), .trk_num(trk_num), .trk_last(trk_last)
    );

    int n_tests = 0, n_fail = 0;
    logic [28:0] hits [256];
    int nh;
    int bocc [NL][RING];
    int bidx [NL][RING];
    int exp_n, cap_n;
    int exp_idx [512], exp_trk [512], cap_idx [512], cap_trk [512];
    bit exp_last [512], cap_last [512];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int wrapg(input int s);
        if (s < 0) return s + RING;
        if (s >= RING) return s - RING;
        return s;
    endfunction

    function automatic int offs(input int k);
        case (k)
            0: return 0;  1: return 1;  2: return -1;
            3: return 2;  4: return -2; default: return 3;
        endcase
    endfunction

    task automatic add_hit(input int layer, input int g);
        hits[nh] = {3'(g / TPS), 4'(layer), 6'(g % TPS), 16'($urandom)};
        nh++;
    endtask

    task automatic add_raw(input int seg, input int layer, input int tube);
        hits[nh] = {3'(seg), 4'(layer), 6'(tube), 16'($urandom)};
        nh++;
    endtask

    // Reference: builds expected beats from the requirements.
    task automatic model();
        int cnt, trk, chain [NL];
        for (int l = 0; l < NL; l++)
            for (int p = 0; p < RING; p++) bocc[l][p] = 0;
        cnt = 0;
        for (int i = 0; i < nh; i++) begin
            int seg, lay, tube;
            seg  = int'(hits[i][28:26]);
            lay  = int'(hits[i][25:22]);
            tube = int'(hits[i][21:16]);
            if (seg < NS && lay < NL && tube < TPS && cnt < MAXH) begin
                bocc[lay][seg * TPS + tube] = 1;
                bidx[lay][seg * TPS + tube] = cnt;
            end
            if (cnt < MAXH) cnt++;
        end
        trk = 0;
        exp_n = 0;
        forever begin
            int p, len, layer;
            p = -1;
            for (int q = RING - 1; q >= 0; q--) if (bocc[0][q] != 0) p = q;
            if (p < 0) break;
            chain[0] = bidx[0][p];
            bocc[0][p] = 0;
            len = 1;
            layer = 0;
            while (layer < NL - 1) begin
                int nl, found, q;
                nl = layer + 1;
                found = -1;
                for (int k = 0; k < (SMASK[nl] ? 6 : 4); k++) begin
                    q = wrapg(p + offs(k));
                    if (found < 0 && bocc[nl][q] != 0) found = q;
                end
                if (found < 0) break;
                chain[len] = bidx[nl][found];
                bocc[nl][found] = 0;
                len++;
                p = found;
                layer = nl;
            end
            if (len >= MINH) begin
                for (int k = 0; k < len; k++) begin
                    exp_idx[exp_n]  = chain[k];
                    exp_trk[exp_n]  = trk;
                    exp_last[exp_n] = (k == len - 1);
                    exp_n++;
                end
                trk++;
            end
        end
    endtask

    // Output capture away from the active edge.
    always @(negedge clk) begin
        if (rst_n && trk_valid && cap_n < 512) begin
            cap_idx[cap_n]  = int'(trk_hit_idx);
            cap_trk[cap_n]  = int'(trk_num);
            cap_last[cap_n] = trk_last;
            cap_n++;
        end
    end

    task automatic run_event(input string tag);
        int guard;
        model();
        cap_n = 0;
        for (int i = 0; i < nh; i++) begin
            @(negedge clk);
            if (!hit_ready) chk(0, "R2 ready during load", 0, 1);
            hit_valid = 1'b1;
            hit_word  = hits[i];
        end
        @(negedge clk);
        hit_valid = 1'b0;
        evt_end   = 1'b1;
        @(negedge clk);
        evt_end = 1'b0;
        chk(hit_ready == 1'b0, "R2 ready low after end", int'(hit_ready), 0);
        guard = 0;
        while (!hit_ready && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        chk(cap_n == exp_n, {tag, " beat count"}, cap_n, exp_n);
        for (int i = 0; i < cap_n && i < exp_n; i++) begin
            chk(cap_idx[i] == exp_idx[i], {tag, " hit index"}, cap_idx[i], exp_idx[i]);
            chk(cap_trk[i] == exp_trk[i], "R8 tracklet number", cap_trk[i], exp_trk[i]);
            chk(cap_last[i] == exp_last[i], "R8 last flag", int'(cap_last[i]), int'(exp_last[i]));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(hit_ready == 1'b1, "R2 reset ready", int'(hit_ready), 1);
        chk(trk_valid == 1'b0, "R8 reset no output", int'(trk_valid), 0);

        // R1/R2/R8: full-depth chain, one out-of-range hit, one short chain.
        nh = 0;
        for (int l = 0; l < NL; l++) add_hit(l, 5);
        add_raw(5, 0, 3);
        for (int l = 0; l < 3; l++) add_hit(l, 30);
        run_event("R1");
        chk(cap_n == 8, "R8 only long chain emitted", cap_n, 8);
        for (int k = 0; k < 8 && k < cap_n; k++)
            chk(cap_idx[k] == k, "R2 arrival index", cap_idx[k], k);

        // R6: wrap across the ring end in axial and stereo layers.
        nh = 0;
        add_hit(0, 63); add_hit(1, 0); add_hit(2, 63); add_hit(3, 61); add_hit(4, 0);
        run_event("R6");
        chk(cap_n == 5, "R6 wrapped chain length", cap_n, 5);

        // R4: offset priority in an axial layer.
        nh = 0;
        add_hit(0, 10); add_hit(1, 9); add_hit(1, 11); add_hit(1, 12);
        add_hit(2, 12); add_hit(3, 12);
        run_event("R4");
        chk(cap_n >= 2 && cap_idx[1] == 2, "R4 picks +1 before -1", cap_idx[1], 2);

        // R5: +3 reaches a stereo layer but not an axial one.
        nh = 0;
        add_hit(0, 20); add_hit(1, 20); add_hit(2, 20); add_hit(3, 23); add_hit(4, 23);
        add_hit(0, 40); add_hit(1, 43); add_hit(2, 43); add_hit(3, 43);
        run_event("R5");
        chk(cap_n == 5, "R5 stereo-only offset", cap_n, 5);

        // R3/R7: seed order and hits shared between seeds.
        nh = 0;
        add_hit(0, 40); add_hit(0, 5); add_hit(0, 6);
        add_hit(1, 5); add_hit(2, 5); add_hit(3, 5);
        add_hit(1, 40); add_hit(2, 40); add_hit(3, 40);
        run_event("R7");
        chk(cap_n >= 1 && cap_idx[0] == 1, "R3 lowest seed first", cap_idx[0], 1);
        chk(cap_n == 8, "R7 used hits not reused", cap_n, 8);
        chk(cap_n >= 5 && cap_trk[4] == 1, "R8 second tracklet number", cap_trk[4], 1);

        // R9: leftovers of one event must not extend a chain in the next.
        nh = 0;
        add_hit(1, 50); add_hit(2, 50); add_hit(3, 50);
        run_event("R9");
        nh = 0;
        add_hit(0, 50);
        run_event("R9");
        chk(cap_n == 0, "R9 no leftover hits", cap_n, 0);

        // Random events: overlapping chains, noise and out-of-range words.
        for (int e = 0; e < 40; e++) begin
            int ntr;
            nh = 0;
            ntr = 1 + int'($urandom % 5);
            for (int t = 0; t < ntr; t++) begin
                int p, len;
                p = int'($urandom % RING);
                len = 2 + int'($urandom % 7);
                for (int l = 0; l < len; l++) begin
                    add_hit(l, p);
                    if (l + 1 < NL)
                        p = wrapg(p + offs(int'($urandom % (SMASK[l + 1] ? 6 : 4))));
                end
            end
            for (int n = 0; n < int'($urandom % 8); n++)
                add_hit(int'($urandom % NL), int'($urandom % RING));
            if ($urandom % 3 == 0) add_raw(int'($urandom % 8), int'($urandom % 16), int'($urandom % 64));
            for (int i = 0; i < nh; i++) begin
                int j;
                logic [28:0] tmp;
                j = int'($urandom % nh);
                tmp = hits[i]; hits[i] = hits[j]; hits[j] = tmp;
            end
            run_event("R6 random");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule